// File: doc/BRIEF.md
# Condition Register Bit Logic Unit

This block keeps a 32-bit condition register and executes the eight single-bit logical operations defined on it. Each instruction word names one destination bit and two source bits. The block reads both source bits, combines them with one of eight two-input boolean functions, and writes the result into the destination bit. Every other bit of the register keeps its value.

The register is split into eight 4-bit fields. Inside each field the four flags are, from the most significant end: less-than, greater-than, equal and summary-overflow. A 5-bit bit number holds the field in its upper three bits and the flag in its lower two bits. An instruction is issued with a one-cycle valid strobe. The updated register appears on the next cycle together with a one-cycle `done` pulse. A word that the block does not recognise gives a one-cycle `illegal` pulse instead. A load strobe writes the whole register in one step.

Top module: `crlu_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `cr_value` is 0 and `done` and `illegal` are 0 until the first operation.
- R2: A word is legal only when bits 31..26 equal 19 and bits 10..1 hold one of the ten-bit codes 257, 225, 449, 193, 33, 289, 129 or 417. Bit 0 has no effect on matching or on the result.
- R3: The destination number is taken from bits 25..21, source A from bits 20..16 and source B from bits 15..11. Bit number n names `cr_value[31-n]`. Its field is n[4:2] and its flag is n[1:0], with 0=lt, 1=gt, 2=eq and 3=so.
- R4: The codes select these results: 257 gives a&b, 225 gives ~(a&b), 449 gives a|b, 193 gives a^b, 33 gives ~(a|b), 289 gives ~(a^b), 129 gives a&~b and 417 gives a|~b. Here a is the source A bit and b is the source B bit.
- R5: A legal instruction changes at most the destination bit. The other 31 bits keep their previous values.
- R6: Sources and destination may share a field or be the same bit. Both sources are taken from the register value as it was before the write.
- R7: After a cycle with `insn_valid` high and a legal word, the new register value and a one-cycle `done` pulse both appear on the following cycle.
- R8: After a cycle with `insn_valid` high and an illegal word, `illegal` is high for one cycle, `done` stays 0 and the register does not change.
- R9: After a cycle with `load_en` high, `cr_value` equals `load_value`.
- R10: When `load_en` and `insn_valid` are high in the same cycle, the load wins. The instruction is dropped and raises neither `done` nor `illegal`.
- R11: In a cycle with neither `load_en` nor `insn_valid`, the register does not change and no pulse follows, whatever is on `insn_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| insn_valid | input | 1 | Instruction strobe |
| insn_word | input | 32 | Instruction word |
| load_en | input | 1 | Whole-register load strobe |
| load_value | input | 32 | Value to load |
| cr_value | output | 32 | Current condition register |
| done | output | 1 | Pulses for one cycle after a legal instruction is executed |
| illegal | output | 1 | Pulses for one cycle after an unrecognised word is issued |

## Verification
The register is visible on `cr_value` at every cycle. A wrong bit index, a reversed bit order or a wrong function therefore shows at the ports on the first cycle after the faulty instruction, compared against a bench model of the register. A decode fault shows up as a missing `done` or a stray `illegal` pulse one cycle after issue. A write that touches neighbouring bits changes bits the model kept, and does so at once. A loss of read-before-write ordering on overlapping operands shows only for the self-referencing cases, so those are driven on purpose.

// File: rtl/crlu_pkg.sv
package crlu_pkg;

  localparam int unsigned PRIMARY_OP = 19;

  typedef enum logic [2:0] {
    FN_AND, FN_NAND, FN_OR, FN_XOR, FN_NOR, FN_EQV, FN_ANDC, FN_ORC
  } crlu_fn_e;

  typedef struct packed {
    logic       legal;
    crlu_fn_e   fn;
    logic [4:0] dst;
    logic [4:0] src_a;
    logic [4:0] src_b;
  } crlu_dec_s;

endpackage

// File: rtl/crlu_rst_sync.sv
module crlu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/crlu_decode.sv
module crlu_decode
  import crlu_pkg::*;
(
  input  logic [31:0] word,
  output crlu_dec_s   dec
);
  logic     op_ok;
  logic     xo_ok;
  crlu_fn_e fn_sel;

  assign op_ok = (word[31:26] == 6'(PRIMARY_OP));

  always_comb begin
    xo_ok  = 1'b1;
    fn_sel = FN_AND;
    unique case (word[10:1])
      10'd257: fn_sel = FN_AND;
      10'd225: fn_sel = FN_NAND;
      10'd449: fn_sel = FN_OR;
      10'd193: fn_sel = FN_XOR;
      10'd33:  fn_sel = FN_NOR;
      10'd289: fn_sel = FN_EQV;
      10'd129: fn_sel = FN_ANDC;
      10'd417: fn_sel = FN_ORC;
      default: xo_ok  = 1'b0;
    endcase
  end

  always_comb begin
    dec.legal = op_ok & xo_ok;
    dec.fn    = fn_sel;
    dec.dst   = word[25:21];
    dec.src_a = word[20:16];
    dec.src_b = word[15:11];
  end
endmodule

// File: rtl/crlu_bitsel.sv
module crlu_bitsel #(
  parameter int unsigned CR_W  = 32,
  parameter int unsigned IDX_W = $clog2(CR_W)
) (
  input  logic [CR_W-1:0]  cr,
  input  logic [IDX_W-1:0] num,
  output logic [IDX_W-1:0] pos,
  output logic             bit_out
);
  assign pos     = IDX_W'(CR_W - 1) - num;
  assign bit_out = cr[pos];
endmodule

// File: rtl/crlu_boolfn.sv
module crlu_boolfn
  import crlu_pkg::*;
(
  input  crlu_fn_e fn,
  input  logic     a,
  input  logic     b,
  output logic     y
);
  logic [3:0] table_v;

  always_comb begin
    unique case (fn)
      FN_AND:  table_v = 4'b1000;
      FN_NAND: table_v = 4'b0111;
      FN_OR:   table_v = 4'b1110;
      FN_XOR:  table_v = 4'b0110;
      FN_NOR:  table_v = 4'b0001;
      FN_EQV:  table_v = 4'b1001;
      FN_ANDC: table_v = 4'b0100;
      FN_ORC:  table_v = 4'b1101;
      default: table_v = 4'b0000;
    endcase
  end

  assign y = table_v[{a, b}];
endmodule

// File: rtl/crlu_unit.sv
module crlu_unit
  import crlu_pkg::*;
#(
  parameter int unsigned NUM_FIELDS = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic [31:0] insn_word,
  input  logic        load_en,
  input  logic [31:0] load_value,
  output logic [31:0] cr_value,
  output logic        done,
  output logic        illegal
);
  localparam int unsigned CR_W  = NUM_FIELDS * 4;
  localparam int unsigned IDX_W = $clog2(CR_W);

  logic            rst_n_s;
  crlu_dec_s       dec;
  logic [CR_W-1:0] cr_q, cr_d;
  logic            cr_en;
  logic            done_q, done_d;
  logic            ill_q, ill_d;
  logic            bit_a, bit_b, bit_t, res;
  logic [IDX_W-1:0] pos_a, pos_b, pos_t;

  crlu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  crlu_decode u_dec (.word(insn_word), .dec(dec));

  crlu_bitsel #(.CR_W(CR_W), .IDX_W(IDX_W)) u_sel_a (
    .cr(cr_q), .num(IDX_W'(dec.src_a)), .pos(pos_a), .bit_out(bit_a)
  );
  crlu_bitsel #(.CR_W(CR_W), .IDX_W(IDX_W)) u_sel_b (
    .cr(cr_q), .num(IDX_W'(dec.src_b)), .pos(pos_b), .bit_out(bit_b)
  );
  crlu_bitsel #(.CR_W(CR_W), .IDX_W(IDX_W)) u_sel_t (
    .cr(cr_q), .num(IDX_W'(dec.dst)), .pos(pos_t), .bit_out(bit_t)
  );

  crlu_boolfn u_fn (.fn(dec.fn), .a(bit_a), .b(bit_b), .y(res));

  // next state: load has priority over an instruction in the same cycle
  always_comb begin
    cr_d   = cr_q;
    cr_en  = 1'b0;
    done_d = 1'b0;
    ill_d  = 1'b0;
    if (load_en) begin
      cr_d  = CR_W'(load_value);
      cr_en = 1'b1;
    end else if (insn_valid) begin
      if (dec.legal) begin
        cr_d[pos_t] = res;
        cr_en       = 1'b1;
        done_d      = 1'b1;
      end else begin
        ill_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cr_q   <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      if (cr_en) cr_q <= cr_d;
      done_q <= done_d;
      ill_q  <= ill_d;
    end
  end

  assign cr_value = 32'(cr_q);
  assign done     = done_q;
  assign illegal  = ill_q;

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    load_en |=> (cr_value == $past(load_value)));

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    load_en |=> (!done && !illegal));

  assert_single_bit_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> ($countones(cr_value ^ $past(cr_value)) <= 1));

  assert_illegal_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    illegal |-> ($stable(cr_value) && !done));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!load_en && !insn_valid) |=> ($stable(cr_value) && !done && !illegal));

  assert_keep_bits_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (insn_valid && !load_en && dec.legal) |=>
      (($past(cr_q) & ~(CR_W'(1) << $past(pos_t))) == (cr_q & ~(CR_W'(1) << $past(pos_t)))));
endmodule

// File: tb/crlu_unit_test.sv
module crlu_unit_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid;
  logic [31:0] insn_word;
  logic        load_en;
  logic [31:0] load_value;
  logic [31:0] cr_value;
  logic        done;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  logic [31:0] model;
  bit finished = 0;

  int xo_list [8] = '{257, 225, 449, 193, 33, 289, 129, 417};

  always #(CLK_PERIOD/2) clk = ~clk;

  crlu_unit uut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .load_en(load_en), .load_value(load_value), .cr_value(cr_value),
    .done(done), .illegal(illegal)
  );

  function automatic logic [31:0] mk(int xo, int bt, int ba, int bb);
    return {6'd19, 5'(bt), 5'(ba), 5'(bb), 10'(xo), 1'b0};
  endfunction

  function automatic bit ref_fn(int xo, bit a, bit b);
    case (xo)
      257: return a & b;
      225: return ~(a & b);
      449: return a | b;
      193: return a ^ b;
      33:  return ~(a | b);
      289: return ~(a ^ b);
      129: return a & ~b;
      default: return a | ~b;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [31:0] v);
    @(negedge clk);
    load_en = 1'b1; load_value = v;
    @(negedge clk);
    load_en = 1'b0;
    model = v;
  endtask

  // issue a legal word and check the updated register and the pulses
  task automatic exec_legal(string req, logic [31:0] w);
    int  bt = w[25:21];
    int  ba = w[20:16];
    int  bb = w[15:11];
    bit  a  = model[31-ba];
    bit  b  = model[31-bb];
    model[31-bt] = ref_fn(int'(w[10:1]), a, b);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = w;
    @(negedge clk);
    insn_valid = 1'b0;
    chk(req, cr_value, model);
    chk({req, " done R7"}, {31'd0, done}, 32'd1);
    chk({req, " illegal R7"}, {31'd0, illegal}, 32'd0);
    @(negedge clk);
    chk("R7 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; insn_valid = 1'b0; insn_word = '0; load_en = 1'b0; load_value = '0;
    repeat (3) @(negedge clk);
    chk("R1 cr in reset", cr_value, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cr after reset", cr_value, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 illegal", {31'd0, illegal}, 32'd0);
    model = '0;
  endtask

  task automatic t_encoding;
    chk("R3 base and", mk(257, 0, 0, 0), 32'h4C000202);
    chk("R3 base orc", mk(417, 0, 0, 0), 32'h4C000342);
    chk("R3 operand fields", mk(257, 15, 5, 20), 32'h4C000202 | 32'h01E5A000);
  endtask

  task automatic t_truth_tables;
    foreach (xo_list[i]) begin
      for (int ab = 0; ab < 4; ab++) begin
        logic [31:0] v = 32'h3C96_5A0F;
        v[26] = ab[1];
        v[11] = ab[0];
        do_load(v);
        exec_legal($sformatf("R4 xo=%0d ab=%0d", xo_list[i], ab), mk(xo_list[i], 15, 5, 20));
      end
    end
  endtask

  task automatic t_same_field;
    foreach (xo_list[i]) begin
      do_load(32'h4000_0000);
      exec_legal("R6 lt<-gt,eq", mk(xo_list[i], 0, 1, 2));
      do_load(32'h6000_0000);
      exec_legal("R6 gt<-gt,eq", mk(xo_list[i], 1, 1, 2));
    end
  endtask

  task automatic t_sweep;
    do_load(32'hC3A5_5A3C);
    for (int n = 0; n < 32; n++) begin
      exec_legal($sformatf("R5 sweep bt=%0d", n), mk(xo_list[n % 8], n, n, (n + 7) % 32));
    end
  endtask

  task automatic t_bit0;
    do_load(32'h0F0F_0F0F);
    exec_legal("R2 bit0 set", mk(193, 9, 4, 30) | 32'h1);
  endtask

  task automatic t_illegal(string req, logic [31:0] w);
    do_load(32'hDEAD_BEEF);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = w;
    @(negedge clk);
    insn_valid = 1'b0;
    chk({req, " R8 illegal"}, {31'd0, illegal}, 32'd1);
    chk({req, " R8 done"}, {31'd0, done}, 32'd0);
    chk({req, " R8 cr"}, cr_value, model);
    @(negedge clk);
    chk("R8 illegal one cycle", {31'd0, illegal}, 32'd0);
  endtask

  task automatic t_load_priority;
    do_load(32'h0000_0000);
    @(negedge clk);
    load_en = 1'b1; load_value = 32'h1234_5678;
    insn_valid = 1'b1; insn_word = mk(449, 0, 0, 0);
    @(negedge clk);
    load_en = 1'b0; insn_valid = 1'b0;
    model = 32'h1234_5678;
    chk("R9 load value", cr_value, model);
    chk("R10 no done", {31'd0, done}, 32'd0);
    @(negedge clk);
    load_en = 1'b1; load_value = 32'hFFFF_0000;
    insn_valid = 1'b1; insn_word = 32'hFC00_0000;
    @(negedge clk);
    load_en = 1'b0; insn_valid = 1'b0;
    model = 32'hFFFF_0000;
    chk("R10 load beats illegal", cr_value, model);
    chk("R10 no illegal", {31'd0, illegal}, 32'd0);
  endtask

  task automatic t_idle;
    do_load(32'h0000_0000);
    @(negedge clk);
    insn_word = mk(33, 7, 8, 9);
    @(negedge clk);
    chk("R11 cr unchanged", cr_value, 32'h0);
    chk("R11 no done", {31'd0, done}, 32'd0);
    chk("R11 no illegal", {31'd0, illegal}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_encoding();
    t_truth_tables();
    t_same_field();
    t_sweep();
    t_bit0();
    t_illegal("bad primary", {6'd31, 15'd0, 10'd257, 1'b0});
    t_illegal("bad xo", mk(256, 3, 4, 5));
    t_load_priority();
    t_idle();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule